// File: doc/BRIEF.md
# Deferred Prefetch Abort Pipeline

This block is a three-stage instruction pipeline skeleton: fetch capture, decode and execute. Each fetched word travels with its fetch address, a valid bit and an abort tag. The bus decoder may flag a fetch as illegal, for example one that falls in an unmapped region. The pipeline does not raise an exception at that moment. It records the flag as a tag on that slot and carries it forward.

The abort is raised only when the tagged slot arrives in execute. At that point the block emits a single-cycle take pulse with the faulting address and discards every younger slot. If a branch redirect flushes the tagged slot first, no abort ever occurs. This situation is common when code runs close to the end of a mapped region and the fetch unit prefetches past the boundary. The word captured with an aborted fetch is never presented as an instruction.

Top module: `prefetch_tag_pipe`

## Requirements
- R1: A fetch accepted with fetch_valid=1, stall=0 and no flush appears at the execute outputs exactly three clock edges later, with exec_valid=1 and the same address and word.
- R2: When a slot tagged as aborted is in execute, exec_valid=0, exec_word is all zeros, abort_take=1 and abort_addr equals that slot's fetch address.
- R3: A tagged slot that a redirect discards before it reaches execute never produces abort_take.
- R4: abort_take lasts exactly one cycle. On the edge that ends it, the two younger slots and that cycle's fetch input are discarded, so back-to-back aborted fetches give only one pulse.
- R5: In a cycle with redirect=1, the instruction in execute is still presented, but it, both younger slots and that cycle's fetch input are discarded at the next edge.
- R6: While stall=1, and no redirect or abort is taken, every stage keeps its word, address, valid bit and tag, and the fetch input is not accepted.
- R7: Asynchronous active-low reset clears every valid bit and abort tag, so exec_valid=0 and abort_take=0.
- R8: An abort in execute is taken even while stall=1, and still gives a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetched word is offered this cycle |
| fetch_addr | input | AW | Address of the offered fetch |
| fetch_word | input | DW | Fetched instruction word |
| fetch_abort | input | 1 | Bus decoder marks this fetch as illegal |
| redirect | input | 1 | Branch or flush from execute |
| stall | input | 1 | Hold all stages |
| exec_valid | output | 1 | A real instruction is in execute |
| exec_addr | output | AW | Address of the execute slot |
| exec_word | output | DW | Instruction in execute, zero for an aborted slot |
| abort_take | output | 1 | One-cycle prefetch abort pulse |
| abort_addr | output | AW | Faulting fetch address while abort_take is high |

## Verification
The bench builds the block with AW=16 and DW=16. Each word is derived from its address, so any mix-up between slots shows at the outputs. With narrow buses, every address in the vector table can be written as one readable byte. The vectors cover these cases: an aborted fetch that executes, an aborted fetch that a redirect flushes, two aborted fetches in a row, and stalls both with and without a pending abort.

// File: rtl/prefetch_tag_pipe.sv
module prefetch_tag_pipe #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [DW-1:0] fetch_word,
  input  logic          fetch_abort,
  input  logic          redirect,
  input  logic          stall,
  output logic          exec_valid,
  output logic [AW-1:0] exec_addr,
  output logic [DW-1:0] exec_word,
  output logic          abort_take,
  output logic [AW-1:0] abort_addr
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] vld_q, tag_q;
  logic [AW-1:0]     addr_q [STAGES];
  logic [DW-1:0]     word_q [STAGES];
  logic              kill;

  assign abort_take = vld_q[LAST] & tag_q[LAST];
  assign kill       = redirect | abort_take;
  assign exec_valid = vld_q[LAST] & ~tag_q[LAST];
  assign exec_addr  = addr_q[LAST];
  assign exec_word  = exec_valid ? word_q[LAST] : '0;
  assign abort_addr = abort_take ? addr_q[LAST] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      for (int i = 0; i < STAGES; i++) begin
        addr_q[i] <= '0;
        word_q[i] <= '0;
      end
    end else if (kill) begin
      vld_q <= '0;
      tag_q <= '0;
    end else if (!stall) begin
      for (int i = LAST; i > 0; i--) begin
        vld_q[i]  <= vld_q[i-1];
        tag_q[i]  <= tag_q[i-1];
        addr_q[i] <= addr_q[i-1];
        word_q[i] <= word_q[i-1];
      end
      vld_q[0]  <= fetch_valid;
      tag_q[0]  <= fetch_valid & fetch_abort;
      addr_q[0] <= fetch_addr;
      word_q[0] <= fetch_word;
    end
  end
endmodule

module prefetch_tag_pipe_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect,
  input logic          stall,
  input logic          exec_valid,
  input logic [AW-1:0] exec_addr,
  input logic [DW-1:0] exec_word,
  input logic          abort_take
);
  a_r2_abort_not_executed: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |-> (!exec_valid && exec_word == '0));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> !abort_take);

  a_r4_younger_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> !exec_valid);

  a_r5_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!exec_valid && !abort_take));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect && !abort_take) |=>
      ($stable(exec_valid) && $stable(exec_addr) && $stable(exec_word) && !abort_take));

  a_r8_take_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_take && stall) |=> (!abort_take && !exec_valid));
endmodule

bind prefetch_tag_pipe prefetch_tag_pipe_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect(redirect), .stall(stall),
  .exec_valid(exec_valid), .exec_addr(exec_addr), .exec_word(exec_word),
  .abort_take(abort_take)
);

// File: tb/test_prefetch_tag_pipe.sv
`timescale 1ns/1ps
module test_prefetch_tag_pipe;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0, fetch_abort = 1'b0, redirect = 1'b0, stall = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [DW-1:0] fetch_word = '0;
  logic exec_valid, abort_take;
  logic [AW-1:0] exec_addr, abort_addr;
  logic [DW-1:0] exec_word;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prefetch_tag_pipe #(.AW(AW), .DW(DW)) i_prefetch_tag_pipe (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_word(fetch_word), .fetch_abort(fetch_abort), .redirect(redirect),
    .stall(stall), .exec_valid(exec_valid), .exec_addr(exec_addr),
    .exec_word(exec_word), .abort_take(abort_take), .abort_addr(abort_addr)
  );

  // {fetch_valid, fetch_abort, redirect, stall, addr byte, exp exec_valid, exp abort_take, exp addr byte}
  localparam logic [21:0] VEC [NV] = '{
    {4'b1000, 8'h01, 2'b00, 8'h00}, {4'b1000, 8'h02, 2'b00, 8'h00},
    {4'b1100, 8'h03, 2'b00, 8'h00}, {4'b1000, 8'h04, 2'b10, 8'h01},
    {4'b1000, 8'h05, 2'b10, 8'h02}, {4'b1000, 8'h06, 2'b01, 8'h03},
    {4'b1000, 8'h07, 2'b00, 8'h00}, {4'b1000, 8'h08, 2'b00, 8'h00},
    {4'b1000, 8'h09, 2'b00, 8'h00}, {4'b1000, 8'h0A, 2'b10, 8'h07},
    {4'b1100, 8'h0B, 2'b10, 8'h08}, {4'b1000, 8'h0C, 2'b10, 8'h09},
    {4'b1010, 8'h0D, 2'b10, 8'h0A}, {4'b1000, 8'h0E, 2'b00, 8'h00},
    {4'b1000, 8'h0F, 2'b00, 8'h00}, {4'b1100, 8'h10, 2'b00, 8'h00},
    {4'b1100, 8'h11, 2'b10, 8'h0E}, {4'b1000, 8'h12, 2'b10, 8'h0F},
    {4'b1000, 8'h13, 2'b01, 8'h10}, {4'b1000, 8'h14, 2'b00, 8'h00},
    {4'b0000, 8'h00, 2'b00, 8'h00}, {4'b0000, 8'h00, 2'b00, 8'h00},
    {4'b1000, 8'h21, 2'b10, 8'h14}, {4'b1000, 8'h22, 2'b00, 8'h00},
    {4'b1001, 8'h23, 2'b00, 8'h00}, {4'b1001, 8'h24, 2'b00, 8'h00},
    {4'b1000, 8'h25, 2'b00, 8'h00}, {4'b1000, 8'h26, 2'b10, 8'h21},
    {4'b1001, 8'h27, 2'b10, 8'h22}, {4'b1000, 8'h28, 2'b10, 8'h22},
    {4'b1100, 8'h2A, 2'b10, 8'h25}, {4'b0000, 8'h00, 2'b10, 8'h26},
    {4'b0000, 8'h00, 2'b10, 8'h28}, {4'b0001, 8'h00, 2'b01, 8'h2A},
    {4'b0001, 8'h00, 2'b00, 8'h00}, {4'b0000, 8'h00, 2'b00, 8'h00}
  };

  function automatic logic [DW-1:0] word_of(input logic [7:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic fv, input logic fab, input logic rd, input logic st,
                       input logic [7:0] a);
    fetch_valid = fv; fetch_abort = fab; redirect = rd; stall = st;
    fetch_addr = {8'h10, a}; fetch_word = word_of(a);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset exec_valid", 32'(exec_valid), 0);
    check("R7 reset abort_take", 32'(abort_take), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:10]);
      #1;
      // R1 R2 R3 R4 R5 R6 R8: cases laid out along the table
      check($sformatf("R1/R5/R6 exec_valid step %0d", i), 32'(exec_valid), 32'(VEC[i][9]));
      check($sformatf("R2/R3/R4/R8 abort_take step %0d", i), 32'(abort_take), 32'(VEC[i][8]));
      if (VEC[i][9]) begin
        check($sformatf("R1 exec_addr step %0d", i), 32'(exec_addr), 32'({8'h10, VEC[i][7:0]}));
        check($sformatf("R1 exec_word step %0d", i), 32'(exec_word), 32'(word_of(VEC[i][7:0])));
      end
      if (VEC[i][8]) begin
        check($sformatf("R2 abort_addr step %0d", i), 32'(abort_addr), 32'({8'h10, VEC[i][7:0]}));
        check($sformatf("R2 exec_word zero step %0d", i), 32'(exec_word), 0);
      end
    end
    // R7: reset in flight clears tagged and valid slots
    @(negedge clk); drive(1, 1, 0, 0, 8'h40);
    @(negedge clk); drive(1, 0, 0, 0, 8'h41);
    @(negedge clk); drive(0, 0, 0, 0, 8'h00);
    rst_n = 1'b0;
    #1;
    check("R7 in-flight reset exec_valid", 32'(exec_valid), 0);
    check("R7 in-flight reset abort_take", 32'(abort_take), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R7 no slot survives reset valid", 32'(exec_valid), 0);
      check("R7 no slot survives reset take", 32'(abort_take), 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule